// File: doc/BRIEF.md
# Zero-Overhead Counted Loop Sequencer

This block runs beside the fetch stage of a small in-order processor. It lets a program run a counted loop with no counter update, no compare and no backward branch inside the body. One setup instruction, decoded elsewhere, hands the block four values: its own address, whether it is a 2-byte or a 4-byte encoding, the address of the last instruction of the body, and the number of iterations. The body begins at the instruction directly after the setup instruction. The block works out that start address itself.

The block then watches every instruction that fetch accepts, meaning a cycle in which valid and ready are both high. Suppose the accepted address equals the end address and more than one iteration remains. In that same cycle the block raises a redirect toward the start address and counts one iteration down. When the end instruction is accepted with one iteration left, the block goes idle and raises no redirect, so fetch carries on past the loop. Returning to the top of the body therefore costs no cycle. Only one loop level is held.

The control is a two-state machine. IDLE means no loop is held. RUN means a loop is held. There are four transitions:
- IDLE to RUN on a setup (LOAD).
- RUN to RUN on a setup (RELOAD).
- RUN to RUN on an accepted end instruction that is not the last (WRAP).
- RUN to IDLE on an accepted end instruction that is the last (EXIT).

In every other case the machine keeps its state (HOLD).

Top module: `hwloop_ctrl`

## Requirements
- R1: A synchronous reset, whether at start-up or in the middle of a loop, leaves `loop_active_o` low, `loop_count_o` at 0 and `redirect_o` low once the clock edge has passed.
- R2: The start address, which is driven on `redirect_target_o` during every redirect, equals `setup_pc_i + 2` when `setup_short_i` is 1 and `setup_pc_i + 4` when it is 0. It may therefore be halfword aligned.
- R3: An accepted instruction whose address equals the end address, while active with a remaining count above 1, raises `redirect_o` in that same cycle. `loop_count_o` is one lower after the edge.
- R4: An accepted end instruction, while active with a remaining count of 1, raises no redirect. After the edge, `loop_active_o` is 0 and `loop_count_o` is 0.
- R5: A setup with a count of 0 loads a count of 1, so the body runs exactly once.
- R6: In a cycle with no accept (`fetch_valid_i` or `fetch_ready_i` low), the block raises no redirect and keeps its count and active flag, even when the presented address is the end address.
- R7: A setup while active replaces the start address, end address and count, and the block stays active. When a setup and an accepted end instruction fall in the same cycle, the redirect still comes from the old loop, but the new setup values are the ones stored.
- R8: For trip counts of 1, 2 and 100, with both 2-byte and 4-byte setup encodings, the end instruction is accepted exactly the trip count number of times, and the fetch address sequence follows the loop.
- R9: An accepted instruction whose address is not the end address causes no redirect and no change of count.
- R10: While inactive, no redirect is raised, even at the last end address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| setup_valid_i | input | 1 | Setup instruction decoded this cycle |
| setup_pc_i | input | AW | Address of the setup instruction |
| setup_short_i | input | 1 | 1: setup is a 2-byte encoding, 0: a 4-byte encoding |
| setup_end_i | input | AW | Address of the last body instruction |
| setup_count_i | input | CW | Iteration count (0 is taken as 1) |
| fetch_valid_i | input | 1 | Fetch presents an instruction |
| fetch_ready_i | input | 1 | Downstream takes the instruction |
| fetch_pc_i | input | AW | Address of the presented instruction |
| redirect_o | output | 1 | Fetch must go to `redirect_target_o` next |
| redirect_target_o | output | AW | Loop start address |
| loop_active_o | output | 1 | A loop is held (RUN state) |
| loop_count_o | output | CW | Iterations remaining, including the current one |

## Verification
The bench drives its own fetch stream. It stalls on both valid and ready, so the end address is often shown several times before it is taken. A design that counted on valid alone would then lose iterations and leave the loop early. Trip counts of 0, 1, 2 and 100 probe the boundary between wrapping and falling through. A wrong comparison against 1 shows up as one iteration too many or too few, or as a redirect on the last pass. Setup encodings of 2 and 4 bytes catch a start address that ignores the compressed length. A setup issued inside a running body, and a setup that lands on the same cycle as an end hit, catch a design that lets the decrement override the reload. A reset in the middle of a loop catches state that survives the reset.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    // Control state of the single loop level
    typedef enum logic [0:0] {
        LP_IDLE = 1'b0,
        LP_RUN  = 1'b1
    } lp_state_e;

    // Byte lengths of the two setup encodings
    localparam int unsigned LEN_SHORT = 2;
    localparam int unsigned LEN_FULL  = 4;

endpackage

// File: rtl/hwloop_span.sv
module hwloop_span #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic [AW-1:0] setup_pc_i,
    input  logic          setup_short_i,
    input  logic [CW-1:0] setup_count_i,
    output logic [AW-1:0] start_addr_o,
    output logic [CW-1:0] count_norm_o
);
    import hwloop_pkg::*;

    localparam logic [AW-1:0] INC_SHORT = AW'(LEN_SHORT);
    localparam logic [AW-1:0] INC_FULL  = AW'(LEN_FULL);

    // Body begins right after the setup instruction
    always_comb begin
        start_addr_o = setup_pc_i + (setup_short_i ? INC_SHORT : INC_FULL);
    end

    // A trip count of zero runs the body once
    always_comb begin
        if (setup_count_i == '0) begin
            count_norm_o = CW'(1);
        end else begin
            count_norm_o = setup_count_i;
        end
    end

endmodule

// File: rtl/hwloop_regs.sv
module hwloop_regs #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          load_i,
    input  logic          dec_i,
    input  logic          clr_i,
    input  logic [AW-1:0] start_in_i,
    input  logic [AW-1:0] end_in_i,
    input  logic [CW-1:0] count_in_i,
    output logic [AW-1:0] start_q_o,
    output logic [AW-1:0] end_q_o,
    output logic [CW-1:0] count_q_o,
    output logic          count_gt1_o
);

    logic [AW-1:0] start_q;
    logic [AW-1:0] end_q;
    logic [CW-1:0] count_q;

    // Address pair: written only by a setup
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (load_i) begin
            start_q <= start_in_i;
            end_q   <= end_in_i;
        end
    end

    // Remaining count: a reload takes precedence over a decrement or clear
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= count_in_i;
        end else if (dec_i) begin
            count_q <= count_q - CW'(1);
        end else if (clr_i) begin
            count_q <= '0;
        end
    end

    always_comb begin
        count_gt1_o = (count_q > CW'(1));
    end

    assign start_q_o = start_q;
    assign end_q_o   = end_q;
    assign count_q_o = count_q;

    // R3
    dec_never_below_one_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dec_i && !load_i) |-> (count_q > CW'(1)));

endmodule

// File: rtl/hwloop_fsm.sv
module hwloop_fsm #(
    parameter int unsigned AW = 32
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          setup_i,
    input  logic          accept_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] end_addr_i,
    input  logic          count_gt1_i,
    output logic          load_o,
    output logic          dec_o,
    output logic          clr_o,
    output logic          redirect_o,
    output logic          active_o
);
    import hwloop_pkg::*;

    lp_state_e state_q;
    lp_state_e state_d;
    logic      end_hit;

    always_comb begin
        end_hit = accept_i && (pc_i == end_addr_i);
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LP_IDLE: begin
                if (setup_i) begin
                    state_d = LP_RUN;               // LOAD
                end
            end
            LP_RUN: begin
                if (setup_i) begin
                    state_d = LP_RUN;               // RELOAD
                end else if (end_hit && !count_gt1_i) begin
                    state_d = LP_IDLE;              // EXIT
                end
            end
            default: state_d = LP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= LP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs per state
    always_comb begin
        load_o     = 1'b0;
        dec_o      = 1'b0;
        clr_o      = 1'b0;
        redirect_o = 1'b0;
        active_o   = 1'b0;
        unique case (state_q)
            LP_IDLE: begin
                load_o = setup_i;
            end
            LP_RUN: begin
                active_o   = 1'b1;
                load_o     = setup_i;
                redirect_o = end_hit && count_gt1_i;              // WRAP
                dec_o      = end_hit && count_gt1_i && !setup_i;
                clr_o      = end_hit && !count_gt1_i && !setup_i; // EXIT
            end
            default: begin
                active_o = 1'b0;
            end
        endcase
    end

    // R4
    last_pass_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == LP_RUN && end_hit && !count_gt1_i && !setup_i) |=> (state_q == LP_IDLE));

    // R10
    idle_no_redirect_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == LP_IDLE) |-> !redirect_o);

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          setup_valid_i,
    input  logic [AW-1:0] setup_pc_i,
    input  logic          setup_short_i,
    input  logic [AW-1:0] setup_end_i,
    input  logic [CW-1:0] setup_count_i,
    input  logic          fetch_valid_i,
    input  logic          fetch_ready_i,
    input  logic [AW-1:0] fetch_pc_i,
    output logic          redirect_o,
    output logic [AW-1:0] redirect_target_o,
    output logic          loop_active_o,
    output logic [CW-1:0] loop_count_o
);

    logic          accept;
    logic [AW-1:0] start_calc;
    logic [CW-1:0] count_calc;
    logic          load;
    logic          dec;
    logic          clr;
    logic [AW-1:0] start_q;
    logic [AW-1:0] end_q;
    logic [CW-1:0] count_q;
    logic          count_gt1;

    always_comb begin
        accept = fetch_valid_i && fetch_ready_i;
    end

    hwloop_span #(.AW(AW), .CW(CW)) u_span (
        .setup_pc_i    (setup_pc_i),
        .setup_short_i (setup_short_i),
        .setup_count_i (setup_count_i),
        .start_addr_o  (start_calc),
        .count_norm_o  (count_calc)
    );

    hwloop_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .load_i      (load),
        .dec_i       (dec),
        .clr_i       (clr),
        .start_in_i  (start_calc),
        .end_in_i    (setup_end_i),
        .count_in_i  (count_calc),
        .start_q_o   (start_q),
        .end_q_o     (end_q),
        .count_q_o   (count_q),
        .count_gt1_o (count_gt1)
    );

    hwloop_fsm #(.AW(AW)) u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .setup_i     (setup_valid_i),
        .accept_i    (accept),
        .pc_i        (fetch_pc_i),
        .end_addr_i  (end_q),
        .count_gt1_i (count_gt1),
        .load_o      (load),
        .dec_o       (dec),
        .clr_o       (clr),
        .redirect_o  (redirect_o),
        .active_o    (loop_active_o)
    );

    assign redirect_target_o = start_q;
    assign loop_count_o      = count_q;

    // R6
    stall_holds_count_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!accept && !setup_valid_i) |=> ($stable(loop_count_o) && $stable(loop_active_o)));

    // R6
    stall_no_redirect_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !accept |-> !redirect_o);

    // R3
    wrap_decrements_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (redirect_o && !setup_valid_i) |=> (loop_count_o == $past(loop_count_o) - CW'(1)));

    // R5
    setup_arms_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        setup_valid_i |=> (loop_active_o && loop_count_o != '0));

    // R9
    off_end_no_redirect_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (fetch_pc_i != end_q) |-> !redirect_o);

endmodule

// File: tb/hwloop_ctrl_bench.sv
module hwloop_ctrl_bench;

    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk;
    logic          rst;
    logic          setup_valid;
    logic [AW-1:0] setup_pc;
    logic          setup_short;
    logic [AW-1:0] setup_end;
    logic [CW-1:0] setup_count;
    logic          fetch_valid;
    logic          fetch_ready;
    logic [AW-1:0] fetch_pc;
    logic          redirect;
    logic [AW-1:0] redirect_target;
    logic          loop_active;
    logic [CW-1:0] loop_count;

    int checks   = 0;
    int failures = 0;

    // Behavioural reference state
    bit          m_active = 0;
    int unsigned m_count  = 0;
    int unsigned m_start  = 0;
    int unsigned m_end    = 0;
    bit          exp_red;
    int unsigned red_tgt;

    hwloop_ctrl #(.AW(AW), .CW(CW)) u_hwloop_ctrl (
        .clk_i             (clk),
        .rst_i             (rst),
        .setup_valid_i     (setup_valid),
        .setup_pc_i        (setup_pc),
        .setup_short_i     (setup_short),
        .setup_end_i       (setup_end),
        .setup_count_i     (setup_count),
        .fetch_valid_i     (fetch_valid),
        .fetch_ready_i     (fetch_ready),
        .fetch_pc_i        (fetch_pc),
        .redirect_o        (redirect),
        .redirect_target_o (redirect_target),
        .loop_active_o     (loop_active),
        .loop_count_o      (loop_count)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: run did not end actual=0 expected=1");
        finish_run();
    end

    // One cycle: drive at the falling edge, compare before the rising edge, advance the model
    task automatic step(input bit r, input bit v, input bit rd, input int unsigned pc,
                        input bit sv, input int unsigned spc, input bit ssh,
                        input int unsigned send, input int unsigned scnt);
        bit acc;
        bit at_end;
        string tag;
        @(negedge clk);
        rst         = r;
        fetch_valid = v;
        fetch_ready = rd;
        fetch_pc    = pc;
        setup_valid = sv;
        setup_pc    = spc;
        setup_short = ssh;
        setup_end   = send;
        setup_count = CW'(scnt);
        #3;
        acc     = v && rd;
        at_end  = m_active && acc && (pc == m_end);
        exp_red = at_end && (m_count > 1);
        red_tgt = m_start;
        if (exp_red)          tag = "R3";
        else if (at_end)      tag = "R4";
        else if (!acc)        tag = "R6";
        else if (!m_active)   tag = "R10";
        else                  tag = "R9";
        check(tag, "redirect", redirect, exp_red);
        if (exp_red) check("R2", "target", redirect_target, m_start);
        check("R8", "active", loop_active, m_active);
        check("R8", "count", loop_count, m_count);
        if (r) begin
            m_active = 0;
            m_count  = 0;
        end else if (sv) begin
            m_start  = spc + (ssh ? 2 : 4);
            m_end    = send;
            m_count  = (scnt == 0) ? 1 : scnt;
            m_active = 1;
        end else if (at_end) begin
            if (m_count > 1) m_count--;
            else begin
                m_active = 0;
                m_count  = 0;
            end
        end
    endtask

    // Program: setup at spc, nbody 4-byte body instructions, optional re-setup inside the body
    task automatic run_prog(input int unsigned spc, input bit ssh, input int nbody,
                            input int unsigned cnt, input bit stall, input int resetup_iter);
        int unsigned start  = spc + (ssh ? 2 : 4);
        int unsigned endpc  = start + 4 * (nbody - 1);
        int unsigned stop   = endpc;
        int unsigned pc     = spc;
        bit done = 0;
        bit done2 = 0;
        int hits = 0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            bit v  = !(stall && (cyc % 7 == 2));
            bit rd = !(stall && (cyc % 5 == 3));
            bit acc = v && rd;
            bit sv  = 0;
            bit re  = 0;
            int unsigned s_pc = pc;
            bit s_sh = ssh;
            int unsigned s_end = endpc;
            int unsigned s_cnt = cnt;
            if (done && pc >= stop + 12 && !m_active) break;
            if (acc && !done && pc == spc) sv = 1;
            if (acc && done && !done2 && resetup_iter > 0 && hits == resetup_iter && pc == start + 4) begin
                sv = 1; re = 1; s_sh = 1; s_end = endpc + 2; s_cnt = 3;
                stop = endpc + 2;
            end
            step(0, v, rd, pc, sv, s_pc, s_sh, s_end, s_cnt);
            if (acc) begin
                if (done && !done2 && pc == endpc) hits++;
                if (exp_red) pc = red_tgt;
                else if (sv) pc = pc + (s_sh ? 2 : 4);
                else pc = pc + 4;
            end
            if (sv) done = 1;
            if (re) begin
                done2 = 1;
                @(posedge clk); #1;
                check("R7", "reload active", loop_active, 1);
                check("R7", "reload count", loop_count, 3);
            end
        end
        if (resetup_iter == 0) begin
            if (cnt == 0) check("R5", "end hits for zero count", hits, 1);
            else check("R8", "end hits", hits, cnt);
        end
    endtask

    initial begin
        rst = 1; fetch_valid = 0; fetch_ready = 0; fetch_pc = 0;
        setup_valid = 0; setup_pc = 0; setup_short = 0; setup_end = 0; setup_count = 0;
        repeat (2) @(posedge clk);
        #1;
        check("R1", "reset active", loop_active, 0);
        check("R1", "reset count", loop_count, 0);
        check("R1", "reset redirect", redirect, 0);

        run_prog(32'h100, 0, 4, 1, 0, 0);
        run_prog(32'h200, 1, 3, 2, 1, 0);
        run_prog(32'h400, 0, 5, 100, 1, 0);
        run_prog(32'h800, 1, 2, 100, 0, 0);
        run_prog(32'hA00, 1, 3, 1, 1, 0);
        run_prog(32'hC00, 0, 3, 2, 0, 0);
        run_prog(32'h1000, 1, 3, 0, 1, 0);
        run_prog(32'h2000, 0, 4, 5, 1, 2);

        // Same-cycle setup and end hit: redirect from old loop, new values stored (R7)
        step(0, 1, 1, 32'h3000, 1, 32'h3000, 0, 32'h3008, 5);
        step(0, 1, 1, 32'h3004, 0, 0, 0, 0, 0);
        step(0, 1, 1, 32'h3008, 1, 32'h3008, 1, 32'h3100, 7);
        check("R7", "same-cycle redirect", exp_red, 1);
        @(posedge clk); #1;
        check("R7", "same-cycle count", loop_count, 7);
        check("R7", "same-cycle active", loop_active, 1);

        // Stalled end address holds state (R6)
        step(0, 1, 0, 32'h3100, 0, 0, 0, 0, 0);
        step(0, 0, 1, 32'h3100, 0, 0, 0, 0, 0);
        @(posedge clk); #1;
        check("R6", "stall count", loop_count, 7);

        // Mid-loop synchronous reset (R1)
        step(1, 1, 1, 32'h3100, 0, 0, 0, 0, 0);
        @(posedge clk); #1;
        check("R1", "mid reset active", loop_active, 0);
        check("R1", "mid reset count", loop_count, 0);

        // Inactive at the old end address (R10)
        step(0, 1, 1, 32'h3100, 0, 0, 0, 0, 0);
        check("R10", "idle redirect", exp_red, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);

        finish_run();
    end

endmodule